// File: doc/BRIEF.md
# Ordered Power-Down Sequencer with Shared Source-Select Pin

This block owns one external input pin whose meaning is set by a configuration bit. In power-down mode the pin is an active-low sleep request. While it is low, the block shuts the part down in a fixed order. It first asks the neighbouring output-enable block to park the main divided output, using that block's own rule against truncated pulses. Next it gates the buffered reference output off on a low phase. Only then does it drop the oscillator enable. In the powered-down state both output drivers are released to high impedance. When the pin returns high, the steps run in reverse. The oscillator is enabled first, and the block counts a programmable number of reference rising edges so that the oscillator can settle. It then reopens the reference output and finally withdraws the disable request for the main output.

In select mode the same pin picks the reference source live: high selects the internal oscillator and low selects the external reference. This overrides the stored source bit. The buffered reference output always carries the selected source. It ignores the main output enable and can be turned off permanently by a configuration bit.

All inputs, including the reference levels, are treated as levels sampled on the master clock `clk`. The shared pin passes through a synchronizer before use.

Top module: `pwrdn_seq`

## Requirements
- R1: When `cfg_pd_mode`=0, a high on `pin_pd_sel` selects `ref_int` and a low selects `ref_ext`, whatever `cfg_src_ext` holds. `ref_out` shows the selected level 3 clocks after a pin change and 1 clock after a reference level change.
- R2: When `cfg_pd_mode`=1 and the pin is high, the part keeps running. The source comes from `cfg_src_ext` (1 = external, 0 = internal), and `main_dis_req` stays 0.
- R3: When `cfg_pd_mode`=1, a low on the pin raises `main_dis_req`. `osc_en` and `ref_oe` stay 1 until `main_dis_ack` has been seen high.
- R4: The reference output is closed and reopened only while the selected reference is low. No high pulse on `ref_out` is ever shorter than a full high phase of the reference.
- R5: `osc_en` falls only after `main_dis_ack` is high and `ref_out` is low. `main_oe` and `ref_oe` fall in the same cycle as `osc_en`.
- R6: While powered down, `osc_en`, `main_oe`, `ref_oe` and `ref_out` are all 0 and `main_dis_req` is 1. This holds until the pin returns high.
- R7: On wake, `osc_en` rises first. `ref_oe`, `main_oe` and the reference gating return only after `cfg_stab_cnt` rising edges of the selected reference. A count of 0 means no wait.
- R8: `main_dis_req` falls only after the reference output is enabled again. The sequencer then waits for `main_dis_ack` to fall before it can start another shutdown.
- R9: When `cfg_ref_off`=1, `ref_out` is held low and `ref_oe` is 0. Shutdown and wake still complete.
- R10: After reset the block is running: `main_dis_req`=0 and `osc_en`=`main_oe`=`ref_oe`=1. A reset asserted while powered down returns the block to this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pd_mode | input | 1 | 1: pin is power-down request; 0: pin is source select |
| cfg_src_ext | input | 1 | Stored source choice, 1 = external, used in power-down mode |
| cfg_ref_off | input | 1 | 1 disables the reference output permanently |
| cfg_stab_cnt | input | STAB_W | Reference rising edges to wait after oscillator enable |
| pin_pd_sel | input | 1 | Shared asynchronous pin |
| ref_int | input | 1 | Internal oscillator level |
| ref_ext | input | 1 | External reference or crystal level |
| main_dis_ack | input | 1 | Output-enable block reports main output parked |
| main_dis_req | output | 1 | Request to park the main output |
| main_oe | output | 1 | Tri-state enable of the main output |
| ref_out | output | 1 | Gated buffered reference |
| ref_oe | output | 1 | Tri-state enable of the reference output |
| osc_en | output | 1 | Oscillator enable |

## Verification
The closing of the reference gate and a falling edge of the reference can land in the same clock. This happens when the main-output acknowledge arrives exactly as the reference drops. The bench sweeps the acknowledge delay across every phase of an 8-clock reference and runs a full shutdown and wake at each delay. A monitor measures every high run on `ref_out` and counts any that is shorter than the reference high phase. It also checks that `osc_en` falls only after the gate has parked `ref_out` low.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    SQ_RUN       = 3'd0,
    SQ_STOP_MAIN = 3'd1,
    SQ_STOP_REF  = 3'd2,
    SQ_STOP_OSC  = 3'd3,
    SQ_OFF       = 3'd4,
    SQ_WAKE_OSC  = 3'd5,
    SQ_WAKE_REF  = 3'd6,
    SQ_WAKE_MAIN = 3'd7
  } seq_state_e;

  // drivers released while the oscillator is off or still settling
  function automatic logic drivers_live(seq_state_e s);
    return !(s inside {SQ_STOP_OSC, SQ_OFF, SQ_WAKE_OSC});
  endfunction

  function automatic logic osc_live(seq_state_e s);
    return !(s inside {SQ_STOP_OSC, SQ_OFF});
  endfunction

  function automatic logic ref_wanted(seq_state_e s);
    return s inside {SQ_RUN, SQ_STOP_MAIN, SQ_WAKE_REF, SQ_WAKE_MAIN};
  endfunction

  function automatic logic main_parked(seq_state_e s);
    return !(s inside {SQ_RUN, SQ_WAKE_MAIN});
  endfunction

endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pwrdn_ref_gate.sv
module pwrdn_ref_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_lvl,
  input  logic want_on,
  input  logic perm_off,
  output logic gate_out,
  output logic passing
);
  logic pass_q, pass_d, out_d, want_eff;

  assign want_eff = want_on & ~perm_off;

  // open or close only while the reference is low: no truncated high phase
  always_comb begin
    if (want_eff) pass_d = pass_q | ~ref_lvl;
    else          pass_d = pass_q & ref_lvl;
    out_d = pass_d & ref_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q   <= 1'b0;
      gate_out <= 1'b0;
    end else begin
      pass_q   <= pass_d;
      gate_out <= out_d;
    end
  end

  assign passing = pass_q;
endmodule

// File: rtl/pwrdn_stab_timer.sv
module pwrdn_stab_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ref_lvl,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         prev_q, rise, cnt_en;

  assign rise   = ref_lvl & ~prev_q;
  assign done   = run && (cnt_q >= limit);
  assign cnt_en = run && rise && !done;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= ref_lvl;
    end
  end
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAB_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pd_mode,
  input  logic              cfg_src_ext,
  input  logic              cfg_ref_off,
  input  logic [STAB_W-1:0] cfg_stab_cnt,
  input  logic              pin_pd_sel,
  input  logic              ref_int,
  input  logic              ref_ext,
  input  logic              main_dis_ack,
  output logic              main_dis_req,
  output logic              main_oe,
  output logic              ref_out,
  output logic              ref_oe,
  output logic              osc_en
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_q;
  logic                  srst_n;
  logic                  pin_s, src_ext, ref_lvl, pd_req;
  logic                  gate_pass, ref_on_ack, ref_off_ack, stab_done;
  seq_state_e            state_q, state_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_q[RST_STAGES-1];

  pwrdn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (pin_pd_sel),
    .q     (pin_s)
  );

  assign src_ext = cfg_pd_mode ? cfg_src_ext : ~pin_s;
  assign ref_lvl = src_ext ? ref_ext : ref_int;
  assign pd_req  = cfg_pd_mode & ~pin_s;

  pwrdn_ref_gate u_ref_gate (
    .clk      (clk),
    .rst_n    (srst_n),
    .ref_lvl  (ref_lvl),
    .want_on  (ref_wanted(state_q)),
    .perm_off (cfg_ref_off),
    .gate_out (ref_out),
    .passing  (gate_pass)
  );

  assign ref_off_ack = ~gate_pass;
  assign ref_on_ack  = gate_pass | cfg_ref_off;

  pwrdn_stab_timer #(.W(STAB_W)) u_stab (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (state_q == SQ_WAKE_OSC),
    .ref_lvl (ref_lvl),
    .limit   (cfg_stab_cnt),
    .done    (stab_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_RUN:       if (pd_req)        state_d = SQ_STOP_MAIN;
      SQ_STOP_MAIN: if (main_dis_ack)  state_d = SQ_STOP_REF;
      SQ_STOP_REF:  if (ref_off_ack)   state_d = SQ_STOP_OSC;
      SQ_STOP_OSC:                     state_d = SQ_OFF;
      SQ_OFF:       if (!pd_req)       state_d = SQ_WAKE_OSC;
      SQ_WAKE_OSC:  if (stab_done)     state_d = SQ_WAKE_REF;
      SQ_WAKE_REF:  if (ref_on_ack)    state_d = SQ_WAKE_MAIN;
      SQ_WAKE_MAIN: if (!main_dis_ack) state_d = SQ_RUN;
      default:                         state_d = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= SQ_RUN;
    else         state_q <= state_d;
  end

  assign main_dis_req = main_parked(state_q);
  assign osc_en       = osc_live(state_q);
  assign main_oe      = drivers_live(state_q);
  assign ref_oe       = drivers_live(state_q) & ~cfg_ref_off;
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_ref_off,
  input logic main_dis_ack,
  input logic main_dis_req,
  input logic main_oe,
  input logic ref_out,
  input logic ref_oe,
  input logic osc_en
);
  AST_REQ_BEFORE_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> main_dis_req); // R3
  AST_OSC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> main_dis_ack && !ref_out); // R5
  AST_HIZ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !main_oe && !ref_oe); // R6
  AST_REF_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !ref_out); // R6
  AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_oe) |-> osc_en); // R7
  AST_RELEASE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_dis_req) |-> osc_en && main_oe); // R8
  AST_PERM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ref_off && !ref_out |=> !ref_out); // R9
endmodule

bind pwrdn_seq pwrdn_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_ref_off  (cfg_ref_off),
  .main_dis_ack (main_dis_ack),
  .main_dis_req (main_dis_req),
  .main_oe      (main_oe),
  .ref_out      (ref_out),
  .ref_oe       (ref_oe),
  .osc_en       (osc_en)
);

// File: tb/pwrdn_seq_tb_top.sv
module pwrdn_seq_tb_top;
  localparam int STAB_W   = 8;
  localparam int REF_HALF = 4;
  localparam int NVEC     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pd_mode = 1'b0, cfg_src_ext = 1'b0, cfg_ref_off = 1'b0;
  logic [STAB_W-1:0] cfg_stab = '0;
  logic pin = 1'b1, vri = 1'b0, vre = 1'b0, use_gen = 1'b0, gi = 1'b0;
  logic ack = 1'b0, mon_en = 1'b0;
  logic ref_int, ref_ext;
  logic main_dis_req, main_oe, ref_out, ref_oe, osc_en;
  int tests = 0, fails = 0, cyc = 0, hcnt = 0, acnt = 0, ack_dly = 2;
  int run_len = 0, short_cnt = 0, rise_cnt = 0;
  logic prev_out = 1'b0;

  always #10 clk = ~clk;

  assign ref_int = use_gen ? (gi & osc_en) : vri;
  assign ref_ext = use_gen ? 1'b0 : vre;

  pwrdn_seq #(.STAB_W(STAB_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pd_mode(cfg_pd_mode), .cfg_src_ext(cfg_src_ext),
    .cfg_ref_off(cfg_ref_off), .cfg_stab_cnt(cfg_stab), .pin_pd_sel(pin),
    .ref_int(ref_int), .ref_ext(ref_ext), .main_dis_ack(ack),
    .main_dis_req(main_dis_req), .main_oe(main_oe), .ref_out(ref_out),
    .ref_oe(ref_oe), .osc_en(osc_en)
  );

  // reference generator, output-enable neighbour model and pulse monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    hcnt = hcnt + 1;
    if (hcnt == REF_HALF) begin gi = ~gi; hcnt = 0; end
    if (ack != main_dis_req) begin
      acnt = acnt + 1;
      if (acnt >= ack_dly) begin ack = main_dis_req; acnt = 0; end
    end else acnt = 0;
    if (ref_out) run_len = run_len + 1;
    else begin
      if (mon_en && run_len > 0 && run_len < REF_HALF) short_cnt = short_cnt + 1;
      run_len = 0;
    end
    if (ref_out && !prev_out) rise_cnt = rise_cnt + 1;
    prev_out = ref_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // fields: pd_mode, src_ext, pin, ref_int, ref_ext, expected ref_out
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0_1_0_0_1_1,  // R1 pin low -> external
    6'b0_0_0_1_0_0,  // R1 stored bit 0 overridden
    6'b0_0_0_0_1_1,  // R1
    6'b0_0_1_1_0_1,  // R1 pin high -> internal
    6'b0_0_1_0_1_0,  // R1
    6'b0_1_1_0_1_0,  // R1 stored bit 1 overridden
    6'b1_0_1_1_0_1,  // R2 stored internal
    6'b1_1_1_1_0_0,  // R2 stored external
    6'b1_1_1_0_1_1,  // R2
    6'b1_0_1_0_1_0   // R2
  };

  task automatic do_cycle(input int dly, input int stab);
    int t0, t1, mark;
    ack_dly = dly; cfg_stab = STAB_W'(stab); short_cnt = 0; mon_en = 1'b1;
    @(negedge clk) pin = 1'b0;
    for (int i = 0; i < 100 && !main_dis_req; i++) @(negedge clk);
    chk(main_dis_req, "R3 req", main_dis_req, 1);
    for (int i = 0; i < 100 && !ack; i++) @(negedge clk);
    chk(osc_en && ref_oe, "R3 osc held until ack", osc_en, 1);
    for (int i = 0; i < 200 && osc_en; i++) @(negedge clk);
    chk(!osc_en && ack && !ref_out, "R5 osc last", osc_en, 0);
    chk(!main_oe && !ref_oe, "R5 drivers released", main_oe + ref_oe, 0);
    repeat (12) @(negedge clk);
    chk(!osc_en && !ref_out && !main_oe && !ref_oe && main_dis_req, "R6 off state",
        {osc_en, ref_out, main_oe, ref_oe}, 0);
    pin = 1'b1;
    for (int i = 0; i < 100 && !osc_en; i++) @(negedge clk);
    t0 = cyc;
    for (int i = 0; i < 400 && !ref_oe; i++) @(negedge clk);
    t1 = cyc;
    chk(main_dis_req && ref_oe, "R8 req held at ref enable", main_dis_req, 1);
    if (stab > 0) chk(t1 - t0 >= (stab - 1) * 2 * REF_HALF, "R7 settle wait", t1 - t0, (stab - 1) * 2 * REF_HALF);
    else          chk(t1 > t0 && t1 - t0 <= 3, "R7 zero wait", t1 - t0, 1);
    for (int i = 0; i < 100 && main_dis_req; i++) @(negedge clk);
    chk(!main_dis_req && ref_oe && osc_en && main_oe, "R8 release", main_dis_req, 0);
    for (int i = 0; i < 100 && ack; i++) @(negedge clk);
    mark = rise_cnt;
    repeat (20) @(negedge clk);
    chk(rise_cnt > mark, "R7 reference resumed", rise_cnt - mark, 1);
    chk(short_cnt == 0, "R4 no short pulse", short_cnt, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails = fails + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!main_dis_req && osc_en && main_oe && ref_oe, "R10 reset state",
        {main_dis_req, osc_en, main_oe, ref_oe}, 4'b0111);

    for (int v = 0; v < NVEC; v++) begin
      {cfg_pd_mode, cfg_src_ext, pin, vri, vre} = VEC[v][5:1];
      repeat (5) @(negedge clk);
      chk(ref_out == VEC[v][0], v < 6 ? "R1 select" : "R2 stored select", ref_out, VEC[v][0]);
      chk(!main_dis_req && osc_en, "R2 running", main_dis_req, 0);
    end

    // R1 latency: pin change seen on ref_out after 3 clocks, not earlier
    cfg_pd_mode = 1'b0; vri = 1'b1; vre = 1'b0; pin = 1'b1;
    repeat (5) @(negedge clk);
    pin = 1'b0;
    repeat (2) @(negedge clk);
    chk(ref_out == 1'b1, "R1 latency early", ref_out, 1);
    @(negedge clk);
    chk(ref_out == 1'b0, "R1 latency 3", ref_out, 0);
    pin = 1'b1;
    repeat (5) @(negedge clk);

    // ordered shutdown and wake, acknowledge swept over every reference phase
    cfg_pd_mode = 1'b1; cfg_src_ext = 1'b0; use_gen = 1'b1;
    repeat (10) @(negedge clk);
    for (int d = 1; d <= 2 * REF_HALF; d++) do_cycle(d, 2);
    do_cycle(3, 0);
    do_cycle(5, 5);

    // R9 permanent reference disable
    cfg_ref_off = 1'b1; mon_en = 1'b0;
    repeat (10) @(negedge clk);
    begin
      int mark;
      mark = rise_cnt;
      repeat (30) @(negedge clk);
      chk(rise_cnt == mark && !ref_out && !ref_oe, "R9 ref off in run", rise_cnt - mark, 0);
      pin = 1'b0;
      for (int i = 0; i < 200 && osc_en; i++) @(negedge clk);
      chk(!osc_en, "R9 shutdown completes", osc_en, 0);
      pin = 1'b1;
      for (int i = 0; i < 400 && main_dis_req; i++) @(negedge clk);
      chk(!main_dis_req && osc_en && main_oe && !ref_oe, "R9 wake completes", main_dis_req, 0);
      repeat (20) @(negedge clk);
      chk(rise_cnt == mark, "R9 ref stays low", rise_cnt - mark, 0);
    end
    cfg_ref_off = 1'b0;
    repeat (20) @(negedge clk);

    // R10 reset while powered down
    pin = 1'b0;
    for (int i = 0; i < 200 && osc_en; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    rst_n = 1'b0; pin = 1'b1;
    @(negedge clk);
    chk(!main_dis_req && osc_en && main_oe && ref_oe, "R10 reset from off",
        {main_dis_req, osc_en, main_oe, ref_oe}, 4'b0111);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule